// File: doc/BRIEF.md
# Exception and Interrupt Control Unit

This block keeps the privileged control state that a 64-bit MIPS-like core uses to enter and leave exception handlers. It holds a Status word, a Cause word, the exception return address (EPC) and the error return address (ErrorEPC). It also holds a free-running Count register that a timer event reloads from a compare value. The pipeline raises a synchronous exception request with a 5-bit code and a delay-slot flag, or asks to take an interrupt. It can also issue a return-from-exception strobe. The block answers one cycle later with a redirect pulse and the address to fetch from.

Interrupt pending is evaluated continuously from the registered state. Eight interrupt lines are sampled into Cause every cycle, and line 7 also carries a sticky timer event. A global disable input hides all interrupts. A software-style write port loads Status, EPC and ErrorEPC while no exception or return is being accepted.

Top module: `cp0_trap_ctrl`

## Requirements
- R1: After reset, Status reads 0x00400000 (only the boot-vector bit, bit 22, set), Cause reads 0, Config reads 0x00C08FF0, Count reads 0, and redirect_vld, ll_clear, irq_pending and fp_count are 0.
- R2: Every clock edge, Cause bits 15:8 load the live interrupt lines, where line 7 is ORed with the timer latch. Cause bit 31 (delay flag) and bits 6:2 (exception code) keep their values across that update.
- R3: irq_pending is 1 only when Status bit 0 (IE) is 1, Status bit 1 (EXL) is 0, Status bit 2 (ERL) is 0, irq_disable is 0, and some Cause bit 15:8 is set whose matching Status mask bit 15:8 is also set.
- R4: An accepted exception with EXL clear loads EPC from cur_pc, sets Cause bit 31 to exc_in_delay, writes the code into Cause bits 6:2 and sets EXL.
- R5: An accepted exception with EXL already set leaves EPC and Cause bit 31 unchanged, updates only the code, and keeps EXL set.
- R6: An exception redirects to 0xFFFFFFFFBFC00380 when the boot-vector bit was 1 before the exception, else to 0xFFFFFFFF80000180.
- R7: On an accepted return with ERL set, ERL clears and the redirect goes to ErrorEPC. Otherwise EXL clears and the redirect goes to EPC. ll_clear pulses for one cycle in both cases.
- R8: timer_fire loads Count with timer_compare and sets a timer latch that drives line 7 until timer_clr. In every other cycle Count increments by one.
- R9: While irq_disable is 1, irq_pending is 0, and irq_take neither raises an exception nor increments fp_count.
- R10: irq_take with irq_pending 1 takes an exception with code 0. irq_take with irq_pending 0 and irq_disable 0 increments fp_count and causes no redirect.
- R11: Priority is exc_req, then a pending irq_take, then eret. A write (wr_sel 0 = Status with writable mask 0x0040FF07, 1 = EPC, 2 = ErrorEPC) is ignored in any cycle where one of those is accepted.
- R12: redirect_vld is 1 in exactly the cycle after an accepted exception or return, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 5 | Code for the requested exception |
| exc_in_delay | input | 1 | Faulting instruction sits in a delay slot |
| cur_pc | input | 64 | Address of the faulting instruction |
| irq_take | input | 1 | Pipeline asks to take an interrupt now |
| irq_lines | input | 8 | Live interrupt lines |
| irq_disable | input | 1 | Global interrupt disable |
| eret | input | 1 | Return-from-exception strobe |
| timer_fire | input | 1 | Timer event: reload Count, raise line 7 |
| timer_clr | input | 1 | Clear the timer latch |
| timer_compare | input | 32 | Value loaded into Count on a timer event |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 Status, 1 EPC, 2 ErrorEPC |
| wr_data | input | 64 | Write data |
| redirect_vld | output | 1 | One-cycle redirect pulse |
| redirect_pc | output | 64 | Redirect target address |
| irq_pending | output | 1 | Interrupt pending flag to the pipeline |
| ll_clear | output | 1 | Clears the load-linked bit |
| status_q | output | 32 | Status word |
| cause_q | output | 32 | Cause word |
| epc_q | output | 64 | Exception return address |
| error_epc_q | output | 64 | Error return address |
| config_q | output | 32 | Constant configuration word |
| count_q | output | 32 | Count register |
| fp_count | output | 16 | Interrupt requests that found nothing pending |

## Verification
The properties assume that the core raises irq_take only after it has sampled irq_pending in the same cycle. They also assume that no write arrives in a cycle that also carries an accepted event, except where R11 is tested. Redirect and vector checks compare against the request inputs one cycle back. They are armed only once a full cycle has passed out of reset, so that values driven during reset are not counted. Stimulus is driven on falling edges with one scenario per task, and every scenario starts from a fresh reset. No prior handler state therefore leaks into the frozen-EPC and nested-exception cases.

// File: rtl/trap_pkg.sv
// Shared constants and types for the exception control unit.
// Assumes a 32-bit Status/Cause layout with eight interrupt lines.
package trap_pkg;
    localparam int ST_IE     = 0;
    localparam int ST_EXL    = 1;
    localparam int ST_ERL    = 2;
    localparam int ST_IM_LO  = 8;
    localparam int ST_BEV    = 22;
    localparam int CA_CODE_LO = 2;
    localparam int CA_IP_LO  = 8;
    localparam int CA_BD     = 31;
    localparam int CODE_W    = 5;

    localparam logic [31:0] STATUS_RST   = 32'h0040_0000;
    localparam logic [31:0] STATUS_WMASK = 32'h0040_FF07;
    localparam logic [31:0] CONFIG_VAL   = 32'h00C0_8FF0;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_EPC    = 2'd1,
        SEL_ERREPC = 2'd2,
        SEL_NONE   = 2'd3
    } wsel_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_EXC  = 2'd1,
        ACT_IRQ  = 2'd2,
        ACT_RET  = 2'd3
    } act_e;
endpackage

// File: rtl/trap_irq_eval.sv
// Interrupt pending evaluation.
// Combines the enable and level bits of Status with the masked Cause lines.
// Assumes mask and pending fields have the same width.
module trap_irq_eval #(
    parameter int NLINES = 8
) (
    input  logic              ie,
    input  logic              exl,
    input  logic              erl,
    input  logic              disable_all,
    input  logic [NLINES-1:0] mask,
    input  logic [NLINES-1:0] lines,
    output logic              pending
);
    // pending only when enabled, outside any handler, and a masked line is set
    always_comb begin
        pending = ie && !exl && !erl && !disable_all && (|(mask & lines));
    end
endmodule

// File: rtl/trap_vector.sv
// Exception target selection.
// Adds a fixed handler offset to the boot or the normal base, chosen by BEV.
module trap_vector #(
    parameter int          XLEN      = 64,
    parameter logic [63:0] BOOT_BASE = 64'hFFFF_FFFF_BFC0_0200,
    parameter logic [63:0] NORM_BASE = 64'hFFFF_FFFF_8000_0000,
    parameter logic [63:0] VEC_OFF   = 64'h0000_0000_0000_0180
) (
    input  logic            bev,
    output logic [XLEN-1:0] target
);
    localparam logic [63:0] BOOT_T = BOOT_BASE + VEC_OFF;
    localparam logic [63:0] NORM_T = NORM_BASE + VEC_OFF;

    // choose the handler address from the boot-vector bit
    always_comb begin
        target = bev ? BOOT_T[XLEN-1:0] : NORM_T[XLEN-1:0];
    end
endmodule

// File: rtl/trap_timer.sv
// Count register and timer line latch.
// Count increments every cycle and is reloaded from the compare value on a
// timer event. The latch holds the timer interrupt line until cleared.
// A fire and a clear in the same cycle leave the latch set.
module trap_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             clr,
    input  logic [CNT_W-1:0] compare,
    output logic [CNT_W-1:0] count,
    output logic             line
);
    // advance or reload the counter
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (fire) count <= compare;
        else           count <= count + 1'b1;
    end

    // hold the timer interrupt line until it is cleared
    always_ff @(posedge clk) begin
        if (!rst_n)     line <= 1'b0;
        else if (fire)  line <= 1'b1;
        else if (clr)   line <= 1'b0;
    end
endmodule

// File: rtl/cp0_trap_ctrl.sv
// Exception and interrupt control unit.
// Holds Status, Cause, EPC and ErrorEPC. It accepts exception, interrupt and
// return requests with fixed priority, and issues a one-cycle redirect.
// Assumes irq_take is raised only after irq_pending was observed.
module cp0_trap_ctrl #(
    parameter int          XLEN      = 64,
    parameter int          NLINES    = 8,
    parameter int          CNT_W     = 32,
    parameter int          FP_W      = 16,
    parameter logic [63:0] BOOT_BASE = 64'hFFFF_FFFF_BFC0_0200,
    parameter logic [63:0] NORM_BASE = 64'hFFFF_FFFF_8000_0000,
    parameter logic [63:0] VEC_OFF   = 64'h0000_0000_0000_0180
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req,
    input  logic [4:0]        exc_code,
    input  logic              exc_in_delay,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic              irq_take,
    input  logic [NLINES-1:0] irq_lines,
    input  logic              irq_disable,
    input  logic              eret,
    input  logic              timer_fire,
    input  logic              timer_clr,
    input  logic [CNT_W-1:0]  timer_compare,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [XLEN-1:0]   wr_data,
    output logic              redirect_vld,
    output logic [XLEN-1:0]   redirect_pc,
    output logic              irq_pending,
    output logic              ll_clear,
    output logic [31:0]       status_q,
    output logic [31:0]       cause_q,
    output logic [XLEN-1:0]   epc_q,
    output logic [XLEN-1:0]   error_epc_q,
    output logic [31:0]       config_q,
    output logic [CNT_W-1:0]  count_q,
    output logic [FP_W-1:0]   fp_count
);
    import trap_pkg::*;

    localparam int IP_HI = CA_IP_LO + NLINES - 1;
    localparam int IM_HI = ST_IM_LO + NLINES - 1;
    localparam int CODE_HI = CA_CODE_LO + CODE_W - 1;

    logic              timer_line;
    logic [NLINES-1:0] lines_live;
    logic [XLEN-1:0]   vec_target;
    logic              pend;
    act_e              act;
    logic              take;
    logic [CODE_W-1:0] code_sel;
    wsel_e             wsel;

    trap_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (timer_fire),
        .clr     (timer_clr),
        .compare (timer_compare),
        .count   (count_q),
        .line    (timer_line)
    );

    trap_irq_eval #(.NLINES(NLINES)) u_eval (
        .ie          (status_q[ST_IE]),
        .exl         (status_q[ST_EXL]),
        .erl         (status_q[ST_ERL]),
        .disable_all (irq_disable),
        .mask        (status_q[IM_HI:ST_IM_LO]),
        .lines       (cause_q[IP_HI:CA_IP_LO]),
        .pending     (pend)
    );

    trap_vector #(
        .XLEN(XLEN), .BOOT_BASE(BOOT_BASE), .NORM_BASE(NORM_BASE), .VEC_OFF(VEC_OFF)
    ) u_vec (
        .bev    (status_q[ST_BEV]),
        .target (vec_target)
    );

    // merge the timer latch onto the highest interrupt line
    always_comb begin
        lines_live = irq_lines;
        lines_live[NLINES-1] = irq_lines[NLINES-1] | timer_line;
    end

    // pick the single event accepted this cycle
    always_comb begin
        if (exc_req)                act = ACT_EXC;
        else if (irq_take && pend)  act = ACT_IRQ;
        else if (eret)              act = ACT_RET;
        else                        act = ACT_NONE;
        take     = (act == ACT_EXC) || (act == ACT_IRQ);
        code_sel = (act == ACT_EXC) ? exc_code : '0;
        wsel     = wr_en ? wsel_e'(wr_sel) : SEL_NONE;
    end

    assign irq_pending = pend;
    assign config_q    = CONFIG_VAL;

    // update Status on exceptions, returns and writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= STATUS_RST;
        end else begin
            case (act)
                ACT_EXC, ACT_IRQ: status_q[ST_EXL] <= 1'b1;
                ACT_RET: begin
                    if (status_q[ST_ERL]) status_q[ST_ERL] <= 1'b0;
                    else                  status_q[ST_EXL] <= 1'b0;
                end
                default: begin
                    if (wsel == SEL_STATUS) status_q <= wr_data[31:0] & STATUS_WMASK;
                end
            endcase
        end
    end

    // refresh Cause lines every cycle and record code and delay flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
        end else begin
            cause_q[IP_HI:CA_IP_LO] <= lines_live;
            if (take) begin
                cause_q[CODE_HI:CA_CODE_LO] <= code_sel;
                if (!status_q[ST_EXL]) cause_q[CA_BD] <= exc_in_delay;
            end
        end
    end

    // capture the return address outside a handler, or take a write
    always_ff @(posedge clk) begin
        if (!rst_n)                                    epc_q <= '0;
        else if (take && !status_q[ST_EXL])            epc_q <= cur_pc;
        else if (act == ACT_NONE && wsel == SEL_EPC)   epc_q <= wr_data;
    end

    // load the error return address from the write port only
    always_ff @(posedge clk) begin
        if (!rst_n)                                      error_epc_q <= '0;
        else if (act == ACT_NONE && wsel == SEL_ERREPC)  error_epc_q <= wr_data;
    end

    // issue the redirect pulse and load-linked clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_vld <= 1'b0;
            redirect_pc  <= '0;
            ll_clear     <= 1'b0;
        end else begin
            redirect_vld <= (act != ACT_NONE);
            ll_clear     <= (act == ACT_RET);
            if (take)                 redirect_pc <= vec_target;
            else if (act == ACT_RET)  redirect_pc <= status_q[ST_ERL] ? error_epc_q : epc_q;
        end
    end

    // count interrupt requests that found nothing pending
    always_ff @(posedge clk) begin
        if (!rst_n)
            fp_count <= '0;
        else if (irq_take && !exc_req && !irq_disable && !pend)
            fp_count <= fp_count + 1'b1;
    end
endmodule

// File: rtl/cp0_trap_ctrl_chk.sv
// Property checker for the exception control unit, bound to the top module.
// Assumes irq_take is only raised with irq_pending observed.
module cp0_trap_ctrl_chk #(
    parameter int          XLEN      = 64,
    parameter logic [63:0] BOOT_BASE = 64'hFFFF_FFFF_BFC0_0200,
    parameter logic [63:0] NORM_BASE = 64'hFFFF_FFFF_8000_0000,
    parameter logic [63:0] VEC_OFF   = 64'h0000_0000_0000_0180
) (
    input logic            clk,
    input logic            rst_n,
    input logic            exc_req,
    input logic            irq_take,
    input logic            eret,
    input logic            irq_disable,
    input logic            irq_pending,
    input logic            redirect_vld,
    input logic [XLEN-1:0] redirect_pc,
    input logic            ll_clear,
    input logic [31:0]     status_q,
    input logic [31:0]     cause_q,
    input logic [XLEN-1:0] epc_q,
    input logic [XLEN-1:0] error_epc_q
);
    localparam logic [63:0] BOOT_T = BOOT_BASE + VEC_OFF;
    localparam logic [63:0] NORM_T = NORM_BASE + VEC_OFF;

    logic armed;
    // arm once a full cycle has passed out of reset
    always_ff @(posedge clk) begin
        armed <= rst_n;
    end

    p_redirect_follows_r12: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        redirect_vld == $past(exc_req || eret || (irq_take && irq_pending)));

    p_exl_set_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(exc_req) |-> status_q[1]);

    p_epc_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && status_q[1]) |=> ($stable(epc_q) && $stable(cause_q[31])));

    p_pending_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> (status_q[0] && !status_q[1] && !status_q[2]));

    p_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_disable |-> !irq_pending);

    p_vector_r6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(exc_req) |-> (redirect_pc == ($past(status_q[22]) ? BOOT_T[XLEN-1:0] : NORM_T[XLEN-1:0])));

    p_eret_erl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eret && !exc_req && !irq_take && status_q[2]) |=>
            (!status_q[2] && ll_clear && redirect_pc == $past(error_epc_q)));
endmodule

bind cp0_trap_ctrl cp0_trap_ctrl_chk #(
    .XLEN(XLEN), .BOOT_BASE(BOOT_BASE), .NORM_BASE(NORM_BASE), .VEC_OFF(VEC_OFF)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .exc_req      (exc_req),
    .irq_take     (irq_take),
    .eret         (eret),
    .irq_disable  (irq_disable),
    .irq_pending  (irq_pending),
    .redirect_vld (redirect_vld),
    .redirect_pc  (redirect_pc),
    .ll_clear     (ll_clear),
    .status_q     (status_q),
    .cause_q      (cause_q),
    .epc_q        (epc_q),
    .error_epc_q  (error_epc_q)
);

// File: tb/cp0_trap_ctrl_test.sv
// Directed bench for the exception control unit: one task per scenario.
module cp0_trap_ctrl_test;
    localparam logic [63:0] VEC_BOOT = 64'hFFFF_FFFF_BFC0_0380;
    localparam logic [63:0] VEC_NORM = 64'hFFFF_FFFF_8000_0180;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0;
    logic [4:0]  exc_code = '0;
    logic        exc_in_delay = 1'b0;
    logic [63:0] cur_pc = '0;
    logic        irq_take = 1'b0;
    logic [7:0]  irq_lines = '0;
    logic        irq_disable = 1'b0;
    logic        eret = 1'b0;
    logic        timer_fire = 1'b0;
    logic        timer_clr = 1'b0;
    logic [31:0] timer_compare = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [63:0] wr_data = '0;
    logic        redirect_vld, irq_pending, ll_clear;
    logic [63:0] redirect_pc, epc_q, error_epc_q;
    logic [31:0] status_q, cause_q, config_q, count_q;
    logic [15:0] fp_count;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cp0_trap_ctrl uut (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
        .exc_in_delay(exc_in_delay), .cur_pc(cur_pc), .irq_take(irq_take),
        .irq_lines(irq_lines), .irq_disable(irq_disable), .eret(eret),
        .timer_fire(timer_fire), .timer_clr(timer_clr), .timer_compare(timer_compare),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .redirect_vld(redirect_vld), .redirect_pc(redirect_pc),
        .irq_pending(irq_pending), .ll_clear(ll_clear), .status_q(status_q),
        .cause_q(cause_q), .epc_q(epc_q), .error_epc_q(error_epc_q),
        .config_q(config_q), .count_q(count_q), .fp_count(fp_count)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; exc_req = 0; exc_code = 0; exc_in_delay = 0; cur_pc = 0;
        irq_take = 0; irq_lines = 0; irq_disable = 0; eret = 0; timer_fire = 0;
        timer_clr = 0; timer_compare = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [63:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
        step();
        wr_en = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 status", status_q, 64'h0040_0000);
        chk("R1 cause", cause_q, 0);
        chk("R1 config", config_q, 64'h00C0_8FF0);
        chk("R1 count", count_q, 0);
        chk("R1 vld", redirect_vld, 0);
        chk("R1 pend", irq_pending, 0);
        chk("R1 fp", fp_count, 0);
    endtask

    task automatic t_cause_mirror();
        do_reset();
        irq_lines = 8'hA5; step();
        chk("R2 ip", cause_q, 64'h0000_A500);
        exc_req = 1; exc_code = 5'd3; step(); exc_req = 0;
        chk("R2 code", cause_q, 64'h0000_A50C);
        irq_lines = 8'h00; step();
        chk("R2 preserve", cause_q, 64'h0000_000C);
    endtask

    task automatic t_pending();
        do_reset();
        irq_lines = 8'h04;
        wr(2'd0, 64'h401);
        chk("R3 pend on", irq_pending, 1);
        irq_lines = 8'h08; step();
        chk("R3 unmasked", irq_pending, 0);
        irq_lines = 8'h04; step();
        chk("R3 pend again", irq_pending, 1);
        wr(2'd0, 64'h403);
        chk("R3 exl blocks", irq_pending, 0);
        wr(2'd0, 64'h405);
        chk("R3 erl blocks", irq_pending, 0);
        wr(2'd0, 64'h400);
        chk("R3 ie off", irq_pending, 0);
    endtask

    task automatic t_exc_nested();
        do_reset();
        exc_req = 1; exc_code = 5'd8; exc_in_delay = 1; cur_pc = 64'h1000; step();
        exc_req = 0;
        chk("R4 epc", epc_q, 64'h1000);
        chk("R4 cause", cause_q, 64'h8000_0020);
        chk("R4 status", status_q, 64'h0040_0002);
        chk("R12 vld", redirect_vld, 1);
        chk("R6 boot vec", redirect_pc, VEC_BOOT);
        step();
        chk("R12 pulse", redirect_vld, 0);
        exc_req = 1; exc_code = 5'd12; exc_in_delay = 0; cur_pc = 64'h2000; step();
        exc_req = 0;
        chk("R5 epc frozen", epc_q, 64'h1000);
        chk("R5 cause", cause_q, 64'h8000_0030);
        chk("R5 exl", status_q, 64'h0040_0002);
    endtask

    task automatic t_vector_normal();
        do_reset();
        wr(2'd0, 64'h0);
        exc_req = 1; exc_code = 5'd4; cur_pc = 64'h3000; step(); exc_req = 0;
        chk("R6 normal vec", redirect_pc, VEC_NORM);
    endtask

    task automatic t_eret();
        do_reset();
        wr(2'd1, 64'h5550);
        wr(2'd2, 64'hABC0);
        wr(2'd0, 64'h6);
        eret = 1; step(); eret = 0;
        chk("R7 erl pc", redirect_pc, 64'hABC0);
        chk("R7 erl status", status_q, 64'h2);
        chk("R7 ll", ll_clear, 1);
        eret = 1; step(); eret = 0;
        chk("R7 exl pc", redirect_pc, 64'h5550);
        chk("R7 exl status", status_q, 64'h0);
        chk("R12 vld eret", redirect_vld, 1);
        step();
        chk("R7 ll pulse", ll_clear, 0);
    endtask

    task automatic t_timer();
        do_reset();
        step();
        chk("R8 inc", count_q, 1);
        timer_fire = 1; timer_compare = 32'h1234; step(); timer_fire = 0;
        chk("R8 load", count_q, 64'h1234);
        step();
        chk("R8 inc2", count_q, 64'h1235);
        chk("R8 line7", cause_q[15], 1);
        timer_clr = 1; step(); timer_clr = 0;
        step();
        chk("R8 line7 clr", cause_q[15], 0);
    endtask

    task automatic t_irq_take();
        do_reset();
        irq_lines = 8'h01;
        wr(2'd0, 64'h101);
        chk("R10 pend", irq_pending, 1);
        irq_take = 1; exc_code = 5'd9; step(); irq_take = 0;
        chk("R10 vld", redirect_vld, 1);
        chk("R10 code0", cause_q[6:2], 0);
        chk("R10 pend off", irq_pending, 0);
        irq_take = 1; step(); irq_take = 0;
        chk("R10 fp", fp_count, 1);
        chk("R10 no redirect", redirect_vld, 0);
    endtask

    task automatic t_disable();
        do_reset();
        irq_lines = 8'h01;
        wr(2'd0, 64'h101);
        irq_disable = 1; #1;
        chk("R9 pend low", irq_pending, 0);
        irq_take = 1; step(); irq_take = 0;
        chk("R9 no redirect", redirect_vld, 0);
        chk("R9 fp kept", fp_count, 0);
        chk("R9 exl clear", status_q[1], 0);
        irq_disable = 0; #1;
        chk("R9 pend back", irq_pending, 1);
    endtask

    task automatic t_priority();
        do_reset();
        wr(2'd1, 64'h7770);
        exc_req = 1; exc_code = 5'd2; eret = 1; cur_pc = 64'h4000;
        wr_en = 1; wr_sel = 2'd0; wr_data = 64'h0;
        step();
        exc_req = 0; eret = 0; wr_en = 0;
        chk("R11 exc wins", redirect_pc, VEC_BOOT);
        chk("R11 write ignored", status_q, 64'h0040_0002);
        chk("R11 ll low", ll_clear, 0);
        chk("R11 epc", epc_q, 64'h4000);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step();
        t_reset();
        t_cause_mirror();
        t_pending();
        t_exc_nested();
        t_vector_normal();
        t_eret();
        t_timer();
        t_irq_take();
        t_disable();
        t_priority();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule